// File: doc/BRIEF.md
# Event Combiner and Core-Level Router

This block gathers 128 peripheral event lines and presents them to the twelve
external priority inputs of a core interrupt controller (core levels 4 to 15).
Every event line from 4 upward latches a sticky flag. The flags form four groups
of 32, and group k covers events 32k to 32k+31. Each group has a mask register
and a combiner. The combiner ORs the unmasked flags of its group into one line.
The four combiner lines take event numbers 0 to 3. Event inputs 0 to 3 never
latch anything, so no combiner can feed back into itself.

Two tables drive the twelve level outputs. The routing table has one entry per
level and selects a single event, from 4 to 127, that drives that level directly.
An entry holding 0 to 3 counts as unmapped. The wiring table has one entry per
combiner and names the level that combiner drives, with an enable bit. A level
output is the OR of its routed event and every enabled combiner wired to it. The
output is registered.

Software reaches the tables through a plain write strobe, which has no back-pressure:
every cycle with `cfg_valid_i` high is one accepted write. A group selector reads
back the raw and the masked flags of one group combinationally.

Top module: `evt_route_top`

## Requirements
- R1: After reset, all flags are clear, all masks are 0, every routing entry is 0 (unmapped), and every level output is low. Wiring entry k is enabled and drives level index 8+k.
- R2: A high level on `evt_i[i]` at a clock edge, for i from 4 to 127, sets flag i. The flag stays set until it is cleared. Inputs 0 to 3 set nothing, and flags 0 to 3 always read 0.
- R3: A write to address 4+k clears flag 32k+b for each data bit b that is 1. If event 32k+b is high at the same edge, the flag stays set.
- R4: A write to address k loads the mask of group k. Mask bit b = 1 hides flag 32k+b from combiner k and leaves the flag itself unchanged. `rd_flag_o` shows the raw flags of group `rd_grp_i`, and `rd_live_o` shows those flags ANDed with the inverted mask.
- R5: Combiner k is high whenever any unmasked flag of group k is set.
- R6: A write to address 8+j loads routing entry j from data bits 6:0, and entry j belongs to core level 4+j. A value from 4 to 127 makes that event's flag drive `lvl_o[j]`, and several entries may name the same event.
- R7: A routing value from 0 to 3 drives nothing, even while the combiner with that number is high.
- R8: A write to address 20+k loads wiring entry k: data bits 3:0 hold the level index and bit 4 is the enable. `lvl_o[j]` is the OR of the routed event and every enabled combiner wired to j.
- R9: `lvl_o` is registered. It changes at the first clock edge after a change in a flag, mask, routing entry or wiring entry.
- R10: A write to an address from 24 to 31 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 128 | Peripheral event lines |
| cfg_valid_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 5 | Register write address |
| cfg_data_i | input | 32 | Register write data |
| rd_grp_i | input | 2 | Group selected for flag readback |
| rd_flag_o | output | 32 | Raw flags of the selected group |
| rd_live_o | output | 32 | Unmasked flags of the selected group |
| lvl_o | output | 12 | Core level requests; bit 0 is level 4 |

## Verification
The bench points routing entries at combiner numbers while that combiner is active. A design that treated those values as real routes would raise the level. It pulses event inputs 0 to 3 with combiner 0 wired to a level, where a design without the reserved slots would latch them and raise that level. It writes a clear while the same event is held high, which catches a design that lets the clear win. It also samples one cycle early after clear, mask and route writes, so an output that is combinational or delayed one cycle too many reads wrong. It also writes to unused addresses, which exposes a decoder that aliases them onto real tables.

// File: rtl/evt_route_pkg.sv
package evt_route_pkg;

  typedef enum logic [2:0] {
    RK_MASK  = 3'd0,
    RK_CLR   = 3'd1,
    RK_ROUTE = 3'd2,
    RK_WIRE  = 3'd3,
    RK_NONE  = 3'd4
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [7:0] idx;
  } reg_sel_t;

  // Address layout: masks, then clears (one per group), then routes (one per
  // level), then combiner wiring (one per group); everything above is unused.
  function automatic reg_sel_t decode_addr(input logic [7:0] a,
                                           input int unsigned nc,
                                           input int unsigned nl);
    reg_sel_t s;
    int unsigned ai;
    ai     = 32'(a);
    s.kind = RK_NONE;
    s.idx  = '0;
    if (ai < nc) begin
      s.kind = RK_MASK;
      s.idx  = 8'(ai);
    end else if (ai < 2 * nc) begin
      s.kind = RK_CLR;
      s.idx  = 8'(ai - nc);
    end else if (ai < 2 * nc + nl) begin
      s.kind = RK_ROUTE;
      s.idx  = 8'(ai - 2 * nc);
    end else if (ai < 3 * nc + nl) begin
      s.kind = RK_WIRE;
      s.idx  = 8'(ai - 2 * nc - nl);
    end
    return s;
  endfunction

endpackage

// File: rtl/evt_flag_bank.sv
module evt_flag_bank
  import evt_route_pkg::*;
#(
  parameter int unsigned N_COMB = 4,
  parameter int unsigned GRP    = 32,
  parameter int unsigned DW     = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_COMB*GRP-1:0]   evt_i,
  input  reg_sel_t                sel,
  input  logic                    wr_en,
  input  logic [DW-1:0]           wdata,
  output logic [N_COMB*GRP-1:0]   flag_q,
  output logic [N_COMB*GRP-1:0]   live_o,
  output logic [N_COMB*GRP-1:0]   clr_vec
);

  localparam int unsigned N_EVT = N_COMB * GRP;
  // Slots 0..N_COMB-1 carry combiner numbers and never latch an input.
  localparam logic [N_EVT-1:0] SRC_OK = {{(N_EVT-N_COMB){1'b1}}, {N_COMB{1'b0}}};

  logic [N_COMB-1:0][GRP-1:0] mask_q;

  for (genvar k = 0; k < N_COMB; k++) begin : g_grp
    logic hit_mask, hit_clr;
    assign hit_mask = wr_en && (sel.kind == RK_MASK) && (sel.idx == 8'(k));
    assign hit_clr  = wr_en && (sel.kind == RK_CLR)  && (sel.idx == 8'(k));

    assign clr_vec[k*GRP +: GRP] = hit_clr ? wdata[GRP-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mask_q[k] <= '0;
      else if (hit_mask) mask_q[k] <= wdata[GRP-1:0];
    end

    assign live_o[k*GRP +: GRP] = flag_q[k*GRP +: GRP] & ~mask_q[k];
  end

  // A new event at the same edge outranks a clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= ((flag_q & ~clr_vec) | evt_i) & SRC_OK;
  end

endmodule

// File: rtl/evt_combiner.sv
module evt_combiner #(
  parameter int unsigned GRP = 32
) (
  input  logic [GRP-1:0] live_i,
  output logic           hit_o
);

  assign hit_o = |live_i;

endmodule

// File: rtl/evt_level_mux.sv
module evt_level_mux
  import evt_route_pkg::*;
#(
  parameter int unsigned N_COMB = 4,
  parameter int unsigned GRP    = 32,
  parameter int unsigned N_LVL  = 12,
  localparam int unsigned N_EVT = N_COMB * GRP,
  localparam int unsigned EW    = $clog2(N_EVT),
  localparam int unsigned LW    = $clog2(N_LVL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EVT-1:0]  flag_i,
  input  logic [N_COMB-1:0] comb_i,
  input  reg_sel_t          sel,
  input  logic              wr_en,
  input  logic [EW-1:0]     route_d,
  input  logic [LW:0]       wire_d,
  output logic [N_LVL-1:0]  lvl_o
);

  logic [N_LVL-1:0][EW-1:0]  route_q;
  logic [N_COMB-1:0][LW-1:0] wlvl_q;
  logic [N_COMB-1:0]         wen_q;
  logic [N_LVL-1:0]          comb_lvl;
  logic [N_LVL-1:0]          direct;

  for (genvar j = 0; j < N_LVL; j++) begin : g_route
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        route_q[j] <= '0;
      else if (wr_en && (sel.kind == RK_ROUTE) && (sel.idx == 8'(j)))
        route_q[j] <= route_d;
    end
    // Values below N_COMB name combiner slots and are treated as unmapped.
    assign direct[j] = (route_q[j] >= EW'(N_COMB)) ? flag_i[route_q[j]] : 1'b0;
  end

  for (genvar k = 0; k < N_COMB; k++) begin : g_wire
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wlvl_q[k] <= LW'(N_LVL - N_COMB + k);
        wen_q[k]  <= 1'b1;
      end else if (wr_en && (sel.kind == RK_WIRE) && (sel.idx == 8'(k))) begin
        wlvl_q[k] <= wire_d[LW-1:0];
        wen_q[k]  <= wire_d[LW];
      end
    end
  end

  always_comb begin
    comb_lvl = '0;
    for (int j = 0; j < N_LVL; j++) begin
      for (int k = 0; k < N_COMB; k++) begin
        if (wen_q[k] && comb_i[k] && (wlvl_q[k] == LW'(j))) comb_lvl[j] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_o <= '0;
    else        lvl_o <= direct | comb_lvl;
  end

endmodule

// File: rtl/evt_route_top.sv
module evt_route_top
  import evt_route_pkg::*;
#(
  parameter int unsigned N_COMB = 4,
  parameter int unsigned GRP    = 32,
  parameter int unsigned N_LVL  = 12,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DW     = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_COMB*GRP-1:0]      evt_i,
  input  logic                       cfg_valid_i,
  input  logic [ADDR_W-1:0]          cfg_addr_i,
  input  logic [DW-1:0]              cfg_data_i,
  input  logic [$clog2(N_COMB)-1:0]  rd_grp_i,
  output logic [GRP-1:0]             rd_flag_o,
  output logic [GRP-1:0]             rd_live_o,
  output logic [N_LVL-1:0]           lvl_o
);

  localparam int unsigned N_EVT = N_COMB * GRP;
  localparam int unsigned EW    = $clog2(N_EVT);
  localparam int unsigned LW    = $clog2(N_LVL);

  reg_sel_t          sel;
  logic [N_EVT-1:0]  flag_q;
  logic [N_EVT-1:0]  live;
  logic [N_EVT-1:0]  clr_vec;
  logic [N_COMB-1:0] comb;

  assign sel = decode_addr(8'(cfg_addr_i), N_COMB, N_LVL);

  evt_flag_bank #(.N_COMB(N_COMB), .GRP(GRP), .DW(DW)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (evt_i),
    .sel     (sel),
    .wr_en   (cfg_valid_i),
    .wdata   (cfg_data_i),
    .flag_q  (flag_q),
    .live_o  (live),
    .clr_vec (clr_vec)
  );

  for (genvar k = 0; k < N_COMB; k++) begin : g_comb
    evt_combiner #(.GRP(GRP)) u_comb (
      .live_i (live[k*GRP +: GRP]),
      .hit_o  (comb[k])
    );
  end

  evt_level_mux #(.N_COMB(N_COMB), .GRP(GRP), .N_LVL(N_LVL)) u_mux (
    .clk     (clk),
    .rst_n   (rst_n),
    .flag_i  (flag_q),
    .comb_i  (comb),
    .sel     (sel),
    .wr_en   (cfg_valid_i),
    .route_d (cfg_data_i[EW-1:0]),
    .wire_d  (cfg_data_i[LW:0]),
    .lvl_o   (lvl_o)
  );

  assign rd_flag_o = flag_q[32'(rd_grp_i) * GRP +: GRP];
  assign rd_live_o = live[32'(rd_grp_i) * GRP +: GRP];

endmodule

// File: rtl/evt_route_chk.sv
module evt_route_chk #(
  parameter int unsigned N_COMB = 4,
  parameter int unsigned GRP    = 32,
  parameter int unsigned N_LVL  = 12,
  localparam int unsigned N_EVT = N_COMB * GRP,
  localparam int unsigned EW    = $clog2(N_EVT)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [N_EVT-1:0]         evt_i,
  input logic [N_LVL-1:0]         lvl_o,
  input logic [N_EVT-1:0]         flag_q,
  input logic [N_EVT-1:0]         clr_vec,
  input logic [N_LVL-1:0][EW-1:0] route_q,
  input logic [N_LVL-1:0]         comb_lvl
);

  localparam logic [N_EVT-1:0] SRC_OK = {{(N_EVT-N_COMB){1'b1}}, {N_COMB{1'b0}}};

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (lvl_o == '0));

  p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i & SRC_OK) != '0) |=> ((flag_q & $past(evt_i & SRC_OK)) == $past(evt_i & SRC_OK)));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~evt_i) != '0) |=> ((flag_q & $past(clr_vec & ~evt_i)) == '0));

  for (genvar j = 0; j < N_LVL; j++) begin : g_lvl
    p_direct_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((route_q[j] >= EW'(N_COMB)) && flag_q[route_q[j]]) |=> lvl_o[j]);

    p_unmapped_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((route_q[j] < EW'(N_COMB)) && !comb_lvl[j]) |=> !lvl_o[j]);
  end

endmodule

bind evt_route_top evt_route_chk #(.N_COMB(N_COMB), .GRP(GRP), .N_LVL(N_LVL)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .evt_i    (evt_i),
  .lvl_o    (lvl_o),
  .flag_q   (u_bank.flag_q),
  .clr_vec  (u_bank.clr_vec),
  .route_q  (u_mux.route_q),
  .comb_lvl (u_mux.comb_lvl)
);

// File: tb/sim_evt_route_top.sv
module sim_evt_route_top;

  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] evt_i = '0;
  logic         cfg_valid_i = 1'b0;
  logic [4:0]   cfg_addr_i = '0;
  logic [31:0]  cfg_data_i = '0;
  logic [1:0]   rd_grp_i = '0;
  logic [31:0]  rd_flag_o, rd_live_o;
  logic [11:0]  lvl_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  evt_route_top u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
    .cfg_valid_i(cfg_valid_i), .cfg_addr_i(cfg_addr_i), .cfg_data_i(cfg_data_i),
    .rd_grp_i(rd_grp_i), .rd_flag_o(rd_flag_o), .rd_live_o(rd_live_o), .lvl_o(lvl_o)
  );

  // {level[3:0], route[6:0], pulsed event[6:0], expected lvl_o[11:0]}
  localparam logic [29:0] VEC [7] = '{
    {4'd4,  7'd32,  7'd32,  12'h010},
    {4'd0,  7'd4,   7'd4,   12'h001},
    {4'd11, 7'd127, 7'd127, 12'h800},
    {4'd5,  7'd1,   7'd40,  12'h000},
    {4'd7,  7'd64,  7'd65,  12'h000},
    {4'd3,  7'd95,  7'd95,  12'h008},
    {4'd9,  7'd95,  7'd95,  12'h208}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_valid_i = 1'b1; cfg_addr_i = a; cfg_data_i = d;
    @(negedge clk);
    cfg_valid_i = 1'b0;
  endtask

  // Ends one negedge after the edge that updates lvl_o from the new flags.
  task automatic pulse(input logic [127:0] v);
    evt_i = v;
    @(negedge clk);
    evt_i = '0;
    @(negedge clk);
  endtask

  task automatic clear_all();
    for (int k = 0; k < 4; k++) wr(5'(4 + k), 32'hFFFF_FFFF);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [127:0] ev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 lvl_o after reset", 32'(lvl_o), 32'h0);
    chk("R1 flags after reset", rd_flag_o, 32'h0);
    chk("R1 live after reset", rd_live_o, 32'h0);
    ev = '0; ev[70] = 1'b1;
    pulse(ev);
    chk("R1 R8 default wiring comb2->lvl10", 32'(lvl_o), 32'h400);

    for (int k = 0; k < 4; k++) wr(5'(20 + k), 32'h0);
    for (int v = 0; v < 7; v++) begin
      clear_all();
      wr(5'(8 + VEC[v][29:26]), 32'(VEC[v][25:19]));
      @(negedge clk);
      chk("R6 R7 idle before pulse", 32'(lvl_o), 32'h0);
      ev = '0; ev[VEC[v][18:12]] = 1'b1;
      pulse(ev);
      chk("R6 R7 vector result", 32'(lvl_o), 32'(VEC[v][11:0]));
    end

    // R2 R3 R9 sticky flag, clear, one-cycle latency
    clear_all();
    wr(5'd10, 32'd50);
    ev = '0; ev[50] = 1'b1;
    pulse(ev);
    chk("R2 routed event raises lvl2", 32'(lvl_o), 32'h004);
    repeat (5) @(negedge clk);
    chk("R2 flag sticky on lvl2", 32'(lvl_o), 32'h004);
    rd_grp_i = 2'd1;
    #1 chk("R2 flag readback bit18", rd_flag_o, 32'h0004_0000);
    wr(5'd5, 32'h0004_0000);
    chk("R9 lvl2 still high one edge after clear", 32'(lvl_o), 32'h004);
    #1 chk("R3 flag cleared", rd_flag_o, 32'h0);
    @(negedge clk);
    chk("R3 R9 lvl2 low after clear", 32'(lvl_o), 32'h000);
    evt_i[50] = 1'b1;
    wr(5'd5, 32'h0004_0000);
    evt_i = '0;
    #1 chk("R3 set wins over clear", rd_flag_o, 32'h0004_0000);

    // R4 R5 R7 R8 combiner, mask, wiring
    clear_all();
    wr(5'd21, 32'h16);
    ev = '0; ev[40] = 1'b1;
    pulse(ev);
    chk("R5 R8 R7 comb1 on lvl6 only", 32'(lvl_o), 32'h040);
    wr(5'd1, 32'h100);
    #1 chk("R4 masked flag leaves live", rd_live_o, 32'h0);
    chk("R4 masked flag still raw", rd_flag_o, 32'h100);
    @(negedge clk);
    chk("R4 R5 mask drops comb1", 32'(lvl_o), 32'h000);
    wr(5'd1, 32'h0);
    @(negedge clk);
    chk("R4 R5 unmask restores comb1", 32'(lvl_o), 32'h040);

    // R2 R5 reserved slots in group 0
    clear_all();
    wr(5'd21, 32'h0);
    wr(5'd20, 32'h10);
    @(negedge clk);
    pulse(128'hF);
    rd_grp_i = 2'd0;
    #1 chk("R2 inputs 0-3 latch nothing", rd_flag_o, 32'h0);
    chk("R5 comb0 quiet on slots 0-3", 32'(lvl_o), 32'h000);
    ev = '0; ev[5] = 1'b1;
    pulse(ev);
    chk("R5 R8 comb0 on lvl0", 32'(lvl_o), 32'h001);

    // R6 R9 route write latency
    wr(5'd18, 32'd5);
    chk("R9 route not yet visible", 32'(lvl_o), 32'h001);
    @(negedge clk);
    chk("R6 R9 route visible next edge", 32'(lvl_o), 32'h401);

    // R10 unused address
    wr(5'd25, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R10 unused address lvl_o", 32'(lvl_o), 32'h401);
    chk("R10 unused address flags", rd_flag_o, 32'h20);
    chk("R10 unused address live", rd_live_o, 32'h20);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule